// File: doc/BRIEF.md
# Outbound Address Window Translator

This block converts addresses leaving a processor into addresses on an external link. It holds a bank of programmable windows. Each window has a 64-bit match value, a 64-bit mask and a 64-bit remap value, each reachable as a low and a high 32-bit word. A fourth word holds the action that goes with the window's traffic. When an address falls inside a window, the bits selected by the mask are replaced with the remap bits. The window's action word is then reported with the result.

Software first programs every field of a window and then sets the window's enable bit, which is bit 0 of the low match word. Translation as a whole also depends on a global enable bit. Lookups are evaluated combinationally and presented one clock later from registers. The downstream request path that uses the result is outside this block.

Top module: `obwin_xlate`

## Requirements
- R1: After a synchronous active-low reset, `out_valid`, `out_miss`, `out_win`, `out_addr` and `out_action` are 0, and every register reads back 0.
- R2: Register map (byte addresses): window w occupies 0x20*w. Its offsets are match low 0x00, match high 0x04, remap low 0x08, remap high 0x0C, mask low 0x10, mask high 0x14 and action 0x18. The global control word is at 0x100, and only its bit 0 (the global enable) is stored. `reg_rdata` shows the register addressed by `reg_addr` one cycle later, and a written value reads back unchanged.
- R3: A window hits when (addr & mask) == (match & mask), with bit 0 of the match value treated as 0 in this compare.
- R4: On a hit, `out_addr` = (addr & ~mask) | (remap & mask), using the winning window's values.
- R5: On a hit, `out_action` is the winning window's full action word (for example 0x0 for memory with attribute bits from bit 20 up, or 0x4 for I/O). On a miss it is 0.
- R6: When several windows hit, the lowest-numbered one wins and its index is shown on `out_win`.
- R7: When no window hits, `out_miss` is 1, `out_addr` equals the input address and `out_win` is 0.
- R8: A window whose enable bit (match low, bit 0) is 0 never hits.
- R9: While the global enable (bit 0 at 0x100) is 0, every lookup misses.
- R10: `out_valid` equals `lk_valid` delayed by one cycle. The other outputs update only on cycles after `lk_valid` was 1, and otherwise hold their values.
- R11: A lookup presented in the same cycle as a register write is translated with the configuration from before that write.
- R12: Accesses whose address has bits [1:0] not 0, or that land on an unmapped offset (0x1C inside a window, or above 0x100), are ignored on write and read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 9 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for `reg_addr` |
| lk_valid | input | 1 | Lookup request valid |
| lk_addr | input | 64 | Address to translate |
| out_valid | output | 1 | Lookup result valid |
| out_addr | output | 64 | Translated (or passed-through) address |
| out_miss | output | 1 | No enabled window matched |
| out_win | output | 3 | Index of winning window |
| out_action | output | 32 | Winning window's action word |

## Verification
A register write and a lookup can happen in the same clock cycle. The result then depends on whether the lookup saw the old window setting or the new one. The bench drives both in the same cycle: it retargets window 0 away from a region and looks up an address in that region at once. It expects the old hit from window 0. The next two lookups must show the new configuration, a miss on the old region and a hit on the new one. Priority between overlapping windows and the effect of the enable bits are judged against a bench model that works from the written register values.

// File: rtl/obwin_pkg.sv
// Package: shared widths, per-window configuration type and offset codes
// for the outbound window translator. Assumes 32-bit register words and
// 64-bit addresses split into low/high words.
package obwin_pkg;

    localparam int ADDR_W = 64;
    localparam int WORD_W = 32;

    // Word offsets (reg_addr[4:2]) inside one window's register block
    localparam logic [2:0] OFS_MATCH_LO = 3'd0;
    localparam logic [2:0] OFS_MATCH_HI = 3'd1;
    localparam logic [2:0] OFS_REMAP_LO = 3'd2;
    localparam logic [2:0] OFS_REMAP_HI = 3'd3;
    localparam logic [2:0] OFS_MASK_LO  = 3'd4;
    localparam logic [2:0] OFS_MASK_HI  = 3'd5;
    localparam logic [2:0] OFS_ACTION   = 3'd6;

    typedef struct packed {
        logic              en;
        logic [ADDR_W-1:0] match;
        logic [ADDR_W-1:0] mask;
        logic [ADDR_W-1:0] remap;
        logic [WORD_W-1:0] action;
    } win_cfg_t;

endpackage

// File: rtl/obwin_regs.sv
// Register file for the window bank and the global enable.
// Assumes NUM_WIN is a power of two; window w sits at byte 0x20*w and the
// global control word directly after the last window. Misaligned and
// unmapped accesses are dropped on write and return 0 on read.
module obwin_regs
    import obwin_pkg::*;
#(
    parameter int NUM_WIN = 8,
    localparam int WIN_AW = $clog2(NUM_WIN),
    localparam int REG_AW = WIN_AW + 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    output win_cfg_t          cfg [NUM_WIN],
    output logic              glob_en
);

    logic [WORD_W-1:0] r_mlo [NUM_WIN];
    logic [WORD_W-1:0] r_mhi [NUM_WIN];
    logic [WORD_W-1:0] r_rlo [NUM_WIN];
    logic [WORD_W-1:0] r_rhi [NUM_WIN];
    logic [WORD_W-1:0] r_klo [NUM_WIN];
    logic [WORD_W-1:0] r_khi [NUM_WIN];
    logic [WORD_W-1:0] r_act [NUM_WIN];

    logic              aligned;
    logic              in_win;
    logic              is_glob;
    logic [WIN_AW-1:0] wsel;
    logic [2:0]        wofs;
    logic [WORD_W-1:0] rd_next;

    // Decode the byte address into window index, word offset and region
    always_comb begin
        aligned = (reg_addr[1:0] == 2'b00);
        in_win  = aligned && !reg_addr[REG_AW-1];
        is_glob = (reg_addr == {1'b1, {(REG_AW-1){1'b0}}});
        wsel    = reg_addr[WIN_AW+4:5];
        wofs    = reg_addr[4:2];
    end

    // Per-window storage, one writer per window
    for (genvar gw = 0; gw < NUM_WIN; gw++) begin : g_win
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                r_mlo[gw] <= '0;
                r_mhi[gw] <= '0;
                r_rlo[gw] <= '0;
                r_rhi[gw] <= '0;
                r_klo[gw] <= '0;
                r_khi[gw] <= '0;
                r_act[gw] <= '0;
            end else if (reg_wr && in_win && (wsel == WIN_AW'(gw))) begin
                case (wofs)
                    OFS_MATCH_LO: r_mlo[gw] <= reg_wdata;
                    OFS_MATCH_HI: r_mhi[gw] <= reg_wdata;
                    OFS_REMAP_LO: r_rlo[gw] <= reg_wdata;
                    OFS_REMAP_HI: r_rhi[gw] <= reg_wdata;
                    OFS_MASK_LO:  r_klo[gw] <= reg_wdata;
                    OFS_MASK_HI:  r_khi[gw] <= reg_wdata;
                    OFS_ACTION:   r_act[gw] <= reg_wdata;
                    default:      ;
                endcase
            end
        end

        // Assemble the 64-bit view of this window for the lookup path
        always_comb begin
            cfg[gw].en     = r_mlo[gw][0];
            cfg[gw].match  = {r_mhi[gw], r_mlo[gw]};
            cfg[gw].mask   = {r_khi[gw], r_klo[gw]};
            cfg[gw].remap  = {r_rhi[gw], r_rlo[gw]};
            cfg[gw].action = r_act[gw];
        end
    end

    // Global enable bit storage
    always_ff @(posedge clk) begin
        if (!rst_n)
            glob_en <= 1'b0;
        else if (reg_wr && is_glob)
            glob_en <= reg_wdata[0];
    end

    // Select the word addressed for read
    always_comb begin
        rd_next = '0;
        if (in_win) begin
            case (wofs)
                OFS_MATCH_LO: rd_next = r_mlo[wsel];
                OFS_MATCH_HI: rd_next = r_mhi[wsel];
                OFS_REMAP_LO: rd_next = r_rlo[wsel];
                OFS_REMAP_HI: rd_next = r_rhi[wsel];
                OFS_MASK_LO:  rd_next = r_klo[wsel];
                OFS_MASK_HI:  rd_next = r_khi[wsel];
                OFS_ACTION:   rd_next = r_act[wsel];
                default:      rd_next = '0;
            endcase
        end else if (is_glob) begin
            rd_next = {{(WORD_W-1){1'b0}}, glob_en};
        end
    end

    // Register the read data for a one-cycle read latency
    always_ff @(posedge clk) begin
        if (!rst_n)
            reg_rdata <= '0;
        else
            reg_rdata <= rd_next;
    end

endmodule

// File: rtl/obwin_match.sv
// Parallel window comparators. For each window it produces a hit flag and
// the translated address. Assumes bit 0 of the match value is the enable
// and so takes no part in the compare.
module obwin_match
    import obwin_pkg::*;
#(
    parameter int NUM_WIN = 8
) (
    input  win_cfg_t          cfg     [NUM_WIN],
    input  logic              glob_en,
    input  logic [ADDR_W-1:0] addr,
    output logic [NUM_WIN-1:0] hit,
    output logic [ADDR_W-1:0] xl_addr [NUM_WIN]
);

    for (genvar gw = 0; gw < NUM_WIN; gw++) begin : g_cmp
        logic [ADDR_W-1:0] cmp_match;

        // Compare the masked address with the masked match value
        always_comb begin
            cmp_match   = {cfg[gw].match[ADDR_W-1:1], 1'b0};
            hit[gw]     = glob_en && cfg[gw].en &&
                          ((addr & cfg[gw].mask) == (cmp_match & cfg[gw].mask));
            xl_addr[gw] = (addr & ~cfg[gw].mask) | (cfg[gw].remap & cfg[gw].mask);
        end
    end

endmodule

// File: rtl/obwin_prio.sv
// Fixed-priority picker: lowest index among hitting windows wins.
// Produces the winning index, a one-hot grant and an any-hit flag.
module obwin_prio #(
    parameter int NUM_WIN = 8,
    localparam int WIN_AW = $clog2(NUM_WIN)
) (
    input  logic [NUM_WIN-1:0] hit,
    output logic [NUM_WIN-1:0] grant,
    output logic [WIN_AW-1:0]  idx,
    output logic               any
);

    // Scan from the top so the lowest hitting index is the last assigned
    always_comb begin
        idx = '0;
        any = 1'b0;
        for (int i = NUM_WIN - 1; i >= 0; i--) begin
            if (hit[i]) begin
                idx = WIN_AW'(i);
                any = 1'b1;
            end
        end
        grant = any ? (NUM_WIN'(1) << idx) : '0;
    end

endmodule

// File: rtl/obwin_xlate.sv
// Outbound address window translator top. Register file, parallel
// comparators and a priority picker feed one output register stage, so a
// lookup result appears one cycle after lk_valid. Assumes NUM_WIN is a
// power of two.
module obwin_xlate
    import obwin_pkg::*;
#(
    parameter int NUM_WIN = 8,
    localparam int WIN_AW = $clog2(NUM_WIN),
    localparam int REG_AW = WIN_AW + 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    input  logic              lk_valid,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              out_valid,
    output logic [ADDR_W-1:0] out_addr,
    output logic              out_miss,
    output logic [WIN_AW-1:0] out_win,
    output logic [WORD_W-1:0] out_action
);

    win_cfg_t           cfg [NUM_WIN];
    logic               glob_en;
    logic [NUM_WIN-1:0] hit;
    logic [ADDR_W-1:0]  xl_addr [NUM_WIN];
    logic [NUM_WIN-1:0] grant;
    logic [WIN_AW-1:0]  win_idx;
    logic               any_hit;

    obwin_regs #(.NUM_WIN(NUM_WIN)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .cfg       (cfg),
        .glob_en   (glob_en)
    );

    obwin_match #(.NUM_WIN(NUM_WIN)) u_match (
        .cfg     (cfg),
        .glob_en (glob_en),
        .addr    (lk_addr),
        .hit     (hit),
        .xl_addr (xl_addr)
    );

    obwin_prio #(.NUM_WIN(NUM_WIN)) u_prio (
        .hit   (hit),
        .grant (grant),
        .idx   (win_idx),
        .any   (any_hit)
    );

    // Register the selected result; hold it when no lookup is presented
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_addr   <= '0;
            out_miss   <= 1'b0;
            out_win    <= '0;
            out_action <= '0;
        end else begin
            out_valid <= lk_valid;
            if (lk_valid) begin
                out_miss   <= !any_hit;
                out_win    <= any_hit ? win_idx : '0;
                out_addr   <= any_hit ? xl_addr[win_idx] : lk_addr;
                out_action <= any_hit ? cfg[win_idx].action : '0;
            end
        end
    end

endmodule

// File: rtl/obwin_xlate_chk.sv
// Property checker for obwin_xlate, attached by bind. It watches the ports
// and the hit/grant/enable nets between the internal blocks.
module obwin_xlate_chk #(
    parameter int NUM_WIN = 8,
    localparam int WIN_AW = $clog2(NUM_WIN)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               lk_valid,
    input logic [63:0]        lk_addr,
    input logic               out_valid,
    input logic [63:0]        out_addr,
    input logic               out_miss,
    input logic [WIN_AW-1:0]  out_win,
    input logic [31:0]        out_action,
    input logic               glob_en,
    input logic [NUM_WIN-1:0] hit,
    input logic [NUM_WIN-1:0] grant
);

    // R10: a lookup produces a valid result on the next cycle
    a_r10_valid_next: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> out_valid);

    // R10: no lookup means no valid result next cycle and held address
    a_r10_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> (!out_valid && $stable(out_addr)));

    // R7: a miss passes the requested address through unchanged
    a_r7_miss_passthru: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_miss) |-> (out_addr == $past(lk_addr) && out_win == '0));

    // R5: a miss reports no action
    a_r5_miss_no_action: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_miss) |-> (out_action == '0));

    // R9: with translation globally off, no window reports a hit
    a_r9_global_off: assert property (@(posedge clk) disable iff (!rst_n)
        !glob_en |-> (hit == '0));

    // R6: at most one window is granted, and only one that hit
    a_r6_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant) && ((grant & ~hit) == '0) && ((hit != '0) == (grant != '0)));

endmodule

bind obwin_xlate obwin_xlate_chk #(.NUM_WIN(NUM_WIN)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .lk_valid   (lk_valid),
    .lk_addr    (lk_addr),
    .out_valid  (out_valid),
    .out_addr   (out_addr),
    .out_miss   (out_miss),
    .out_win    (out_win),
    .out_action (out_action),
    .glob_en    (glob_en),
    .hit        (hit),
    .grant      (grant)
);

// File: tb/obwin_xlate_tb.sv
// Self-checking bench: programs the window bank, sweeps all 32 regions of
// the low-word mask with several address patterns, and compares against a
// model built from shadow copies of the written registers.
module obwin_xlate_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [8:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        lk_valid = 1'b0;
    logic [63:0] lk_addr = '0;
    logic        out_valid;
    logic [63:0] out_addr;
    logic        out_miss;
    logic [2:0]  out_win;
    logic [31:0] out_action;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    logic [31:0] sh [8][8];
    logic        sh_glob = 1'b0;

    always #4 clk = ~clk;

    obwin_xlate u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lk_valid(lk_valid),
        .lk_addr(lk_addr), .out_valid(out_valid), .out_addr(out_addr),
        .out_miss(out_miss), .out_win(out_win), .out_action(out_action)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Update the shadow copy following the R2/R12 map
    task automatic shadow_wr(input logic [8:0] a, input logic [31:0] d);
        if (a[1:0] != 2'b00) return;
        if (a == 9'h100) sh_glob = d[0];
        else if (!a[8] && a[4:2] != 3'd7) sh[a[7:5]][a[4:2]] = d;
    endtask

    task automatic wr(input logic [8:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        shadow_wr(a, d);
    endtask

    task automatic rd_check(input logic [8:0] a, input logic [31:0] exp, input string req);
        @(negedge clk);
        reg_addr = a;
        @(negedge clk);
        check(reg_rdata == exp, req, 64'(reg_rdata), 64'(exp));
    endtask

    // Reference model from R3..R9
    task automatic model(input logic [63:0] a, output bit miss, output logic [2:0] w,
                         output logic [63:0] xa, output logic [31:0] act);
        miss = 1'b1; w = '0; xa = a; act = '0;
        if (!sh_glob) return;
        for (int i = 0; i < 8; i++) begin
            logic [63:0] m, k, r;
            m = {sh[i][1], sh[i][0][31:1], 1'b0};
            r = {sh[i][3], sh[i][2]};
            k = {sh[i][5], sh[i][4]};
            if (sh[i][0][0] && ((a & k) == (m & k))) begin
                miss = 1'b0; w = 3'(i); xa = (a & ~k) | (r & k); act = sh[i][6];
                return;
            end
        end
    endtask

    task automatic look(input logic [63:0] a, input string tag);
        bit          em;
        logic [2:0]  ew;
        logic [63:0] ea;
        logic [31:0] eact;
        model(a, em, ew, ea, eact);
        @(negedge clk);
        lk_valid = 1'b1; lk_addr = a;
        @(negedge clk);
        lk_valid = 1'b0;
        check(out_valid == 1'b1, {tag, " R10 valid"}, 64'(out_valid), 64'd1);
        check(out_miss == em, {tag, " R7 miss"}, 64'(out_miss), 64'(em));
        check(out_addr == ea, {tag, " R4 addr"}, out_addr, ea);
        check(out_win == ew, {tag, " R6 win"}, 64'(out_win), 64'(ew));
        check(out_action == eact, {tag, " R5 action"}, 64'(out_action), 64'(eact));
    endtask

    initial begin
        for (int i = 0; i < 8; i++)
            for (int j = 0; j < 8; j++) sh[i][j] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(out_valid == 1'b0 && out_miss == 1'b0, "R1 out flags", 64'({out_valid, out_miss}), 64'd0);
        check(out_addr == '0 && out_action == '0, "R1 out data", out_addr, 64'd0);
        rd_check(9'h000, 32'd0, "R1 reg match lo");
        rd_check(9'h0F8, 32'd0, "R1 reg action w7");
        rd_check(9'h100, 32'd0, "R1 reg global");

        // R2: write/readback of all window words
        for (int w = 0; w < 8; w++)
            for (int o = 0; o < 7; o++)
                wr(9'(w * 32 + o * 4), 32'hA500_0000 ^ (w << 12) ^ (o << 4) ^ 32'h0000_0F00);
        for (int w = 0; w < 8; w++)
            for (int o = 0; o < 7; o++)
                rd_check(9'(w * 32 + o * 4), 32'hA500_0000 ^ (w << 12) ^ (o << 4) ^ 32'h0000_0F00, "R2 readback");
        wr(9'h100, 32'hFFFF_FFFF);
        rd_check(9'h100, 32'd1, "R2 global only bit0");

        // R12: unmapped and misaligned accesses
        wr(9'h07C, 32'hDEAD_BEEF);
        rd_check(9'h07C, 32'd0, "R12 unmapped offset");
        wr(9'h042, 32'h1234_5678);
        rd_check(9'h040, 32'hA500_0000 ^ (2 << 12) ^ 32'h0000_0F00, "R12 misaligned write dropped");
        rd_check(9'h041, 32'd0, "R12 misaligned read");
        rd_check(9'h104, 32'd0, "R12 above global");

        // Clear bank, then program windows
        for (int w = 0; w < 8; w++)
            for (int o = 0; o < 7; o++) wr(9'(w * 32 + o * 4), 32'd0);
        for (int w = 0; w < 8; w++) begin
            int rg;
            rg = (w == 6) ? 3 : (w == 7) ? 30 : w * 3;
            wr(9'(w * 32 + 4),  32'd0);
            wr(9'(w * 32 + 8),  32'(((16 + w) << 27) | (w << 4)));
            wr(9'(w * 32 + 12), 32'h0000_0100 + 32'(w));
            wr(9'(w * 32 + 16), (w == 5) ? 32'hF800_0001 : 32'hF800_0000);
            wr(9'(w * 32 + 20), 32'h0000_FFFF);
            wr(9'(w * 32 + 24), (w % 2 == 1) ? 32'h4 : 32'(2 << 20));
            wr(9'(w * 32 + 0),  32'(rg << 27) | ((w == 7) ? 32'd0 : 32'd1));
        end

        // R3/R4/R5/R6/R7/R8: sweep every region with four address patterns
        for (int r = 0; r < 32; r++)
            for (int s = 0; s < 4; s++) begin
                logic [31:0] lo;
                logic [31:0] hi;
                lo = 32'(r << 27) | (32'(s) * 32'h0012_3457);
                hi = (s == 3) ? 32'h0001_0000 : (s == 2) ? 32'h0000_0005 : 32'h0;
                look({hi, lo}, "R3 sweep");
            end
        look({32'h0, 32'h1800_0010}, "R6 overlap region3");
        check(out_win == 3'd1, "R6 lowest wins", 64'(out_win), 64'd1);
        look({32'h0, 32'h7800_0001}, "R3 bit0 window5");
        check(out_miss == 1'b1, "R3 match bit0 ignored", 64'(out_miss), 64'd1);
        look({32'h0, 32'hF000_0000}, "R8 disabled window");
        check(out_miss == 1'b1, "R8 disabled no hit", 64'(out_miss), 64'd1);

        // R9: global enable off
        wr(9'h100, 32'd0);
        for (int r = 0; r < 32; r++) look({32'h0, 32'(r << 27)}, "R9 global off");
        wr(9'h100, 32'd1);

        // R10: outputs hold while no lookup is presented
        look({32'h0, 32'h0000_0040}, "R10 setup");
        begin
            logic [63:0] held;
            held = out_addr;
            @(negedge clk); lk_addr = 64'hFFFF_0000_1234_5678;
            @(negedge clk);
            check(out_valid == 1'b0, "R10 idle valid", 64'(out_valid), 64'd0);
            check(out_addr == held, "R10 idle hold", out_addr, held);
        end

        // R11: write and lookup in the same cycle
        begin
            @(negedge clk);
            reg_wr = 1'b1; reg_addr = 9'h000; reg_wdata = 32'hF800_0001;
            lk_valid = 1'b1; lk_addr = 64'h0000_0000_0000_0100;
            @(negedge clk);
            reg_wr = 1'b0; lk_valid = 1'b0;
            check(out_miss == 1'b0 && out_win == 3'd0, "R11 old config used",
                  64'({out_miss, out_win}), 64'd0);
            check(out_addr == 64'h0000_0100_8000_0100, "R11 old translation",
                  out_addr, 64'h0000_0100_8000_0100);
            shadow_wr(9'h000, 32'hF800_0001);
        end
        look(64'h0000_0000_0000_0100, "R11 new config old region");
        look(64'h0000_0000_F800_0100, "R11 new config new region");

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    // Watchdog: an expired run counts as a failed check
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule